// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on separate, unrelated clocks; the two clocks may also come from one source. Words enter on the write clock when a pair of write enables permits it. They leave through a registered output on the read clock when a pair of read enables permits it. The output drives high impedance unless the active-low output enable is low. The depth is a parameter (64 to 8192 words, a power of two).

The write side shares its data input with a threshold loader. When the second write enable is driven low instead of high, the input word goes into one part of the two threshold registers, and the RAM is left alone. The loader steps through the parts in a fixed cycle. The thresholds set when the almost-empty and almost-full flags rise. Full and almost-full are produced on the write clock. Empty and almost-empty are produced on the read clock. Each side sees the other's pointer through a Gray-coded two-flop synchronizer.

Back-pressure on the write side is the full flag, and on the read side the empty flag. A write attempted while full, or a read attempted while empty, is dropped without any effect. No error is raised.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word is written on a rising wr_clk edge when wr_en1_n is 0, wr_en2_ld is 1 and full is 0. Words come out in the order written, with no loss or duplication, under any ratio of the two clocks.
- R2: On a rising wr_clk edge with wr_en1_n at 0 and wr_en2_ld at 0, wr_data is loaded into one threshold part and the RAM is not written. The parts are taken cyclically in this order: almost-empty low, almost-empty high, almost-full low, almost-full high. A low part takes wr_data[8:0] into threshold bits [8:0]. A high part supplies threshold bits above bit 8; it is ignored when the depth needs no more than 9 threshold bits.
- R3: A read happens on a rising rd_clk edge when rd_en1_n and rd_en2_n are both 0 and empty is 0. The output register takes the oldest word at that same edge. With either read enable at 1, the output register holds.
- R4: rd_data equals the output register while out_en_n is 0, and is high impedance (all Z) while out_en_n is 1.
- R5: full is 1 exactly when DEPTH words are held, as seen by the write side. A write attempted while full is dropped and the stored contents are unchanged.
- R6: empty is 1 when no word is held, as seen by the read side. A read attempted while empty leaves the output register and the contents unchanged.
- R8: almost_empty is 1 when the word count seen by the read side is at or below the almost-empty threshold.
- R9: almost_full is 1 when DEPTH minus the word count seen by the write side is at or below the almost-full threshold.
- R10: The asynchronous active-low rst_n empties the FIFO. It sets empty and almost_empty to 1 and full and almost_full to 0. It returns the loader to the almost-empty low part, and it sets both thresholds to 7 when DEPTH is 64 and to 127 otherwise.
- R11: A pointer crosses domains only as Gray code, changing one bit per step. empty falls no more than 4 rd_clk edges after the write into an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_data | input | DW (9) | Write data, or threshold part when loading |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | 1: write to RAM, 0: load threshold part |
| rd_en1_n | input | 1 | Active-low read enable, first |
| rd_en2_n | input | 1 | Active-low read enable, second |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | DW (9) | Registered read data, Z when disabled |
| full | output | 1 | No free word (write domain) |
| almost_full | output | 1 | Free words at or below threshold (write domain) |
| empty | output | 1 | No word held (read domain) |
| almost_empty | output | 1 | Held words at or below threshold (read domain) |

## Verification
The checker assumes that rst_n stays low across at least one edge of each clock. It also assumes that each enable changes only away from the rising edge of its own clock. It takes the thresholds as quasi-static: they are written on the write clock but compared on the read clock, so they are loaded only while the read side is idle. The stimulus drives every input on the falling edge of its own clock and holds reset for several cycles of both clocks. It programs the thresholds right after each reset, before any traffic starts, and changes the read clock period only between traffic phases.

// File: rtl/fifo_pflag_pkg.sv
`timescale 1ns/1ps
package fifo_pflag_pkg;

  // Threshold-loader step; the order is part of the load protocol.
  typedef enum logic [1:0] {
    LD_AE_LO = 2'd0,
    LD_AE_HI = 2'd1,
    LD_AF_LO = 2'd2,
    LD_AF_HI = 2'd3
  } ld_step_e;

  function automatic int default_offset(input int depth);
    return (depth == 64) ? 7 : 127;
  endfunction

endpackage

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray pointer, with conversion back to binary
module fifo_ptr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ sync_q[i];
      bin_out[i] = acc;
    end
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
// Write domain: write pointer, threshold loader, full and almost-full
module fifo_wr_ctl
  import fifo_pflag_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int AW      = 6,
  parameter int DEF_OFS = 7
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          en1_n,
  input  logic          en2_ld,
  input  logic [AW:0]   rd_bin_s,
  output logic          wr_fire,
  output logic [AW:0]   wr_bin,
  output logic [AW:0]   wr_gray,
  output logic [AW-1:0] ae_ofs,
  output logic          full,
  output logic          almost_full
);
  localparam int PW = AW + 1;

  logic [PW-1:0] bin_nx;
  logic [PW-1:0] fill;
  logic [PW-1:0] space;
  logic          ld_fire;
  ld_step_e      step_q;
  logic [AW-1:0] ae_q, af_q;
  logic [AW-1:0] ae_lo_nx, ae_hi_nx, af_lo_nx, af_hi_nx;

  assign fill        = wr_bin - rd_bin_s;
  assign space       = PW'(DEPTH) - fill;
  assign full        = (fill == PW'(DEPTH));
  assign almost_full = (space <= {1'b0, af_q});
  assign wr_fire     = !en1_n && en2_ld && !full;
  assign ld_fire     = !en1_n && !en2_ld;
  assign bin_nx      = wr_bin + PW'(1);
  assign ae_ofs      = ae_q;

  // Split of a threshold into a low part and a high part
  generate
    if (AW > DW) begin : g_wide
      assign ae_lo_nx = {ae_q[AW-1:DW], din};
      assign ae_hi_nx = {din[AW-DW-1:0], ae_q[DW-1:0]};
      assign af_lo_nx = {af_q[AW-1:DW], din};
      assign af_hi_nx = {din[AW-DW-1:0], af_q[DW-1:0]};
    end else begin : g_narrow
      assign ae_lo_nx = din[AW-1:0];
      assign ae_hi_nx = ae_q;
      assign af_lo_nx = din[AW-1:0];
      assign af_hi_nx = af_q;
    end
  endgenerate

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (wr_fire) begin
      wr_bin  <= bin_nx;
      wr_gray <= bin_nx ^ (bin_nx >> 1);
    end
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= LD_AE_LO;
      ae_q   <= AW'(DEF_OFS);
      af_q   <= AW'(DEF_OFS);
    end else if (ld_fire) begin
      step_q <= ld_step_e'(step_q + 2'd1);
      unique case (step_q)
        LD_AE_LO: ae_q <= ae_lo_nx;
        LD_AE_HI: ae_q <= ae_hi_nx;
        LD_AF_LO: af_q <= af_lo_nx;
        LD_AF_HI: af_q <= af_hi_nx;
      endcase
    end
  end
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
// Read domain: read pointer, empty and almost-empty
module fifo_rd_ctl #(
  parameter int AW = 6
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          en1_n,
  input  logic          en2_n,
  input  logic [AW:0]   wr_bin_s,
  input  logic [AW-1:0] ae_ofs,
  output logic          rd_fire,
  output logic [AW:0]   rd_bin,
  output logic [AW:0]   rd_gray,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] level;
  logic [PW-1:0] bin_nx;

  assign level        = wr_bin_s - rd_bin;
  assign empty        = (level == '0);
  assign almost_empty = (level <= {1'b0, ae_ofs});
  assign rd_fire      = !en1_n && !en2_n && !empty;
  assign bin_nx       = rd_bin + PW'(1);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (rd_fire) begin
      rd_bin  <= bin_nx;
      rd_gray <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
// Two-clock storage with a registered read port
module fifo_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 9,
  parameter int AW    = 6
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag
  import fifo_pflag_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 9
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          almost_full,
  output logic          empty,
  output logic          almost_empty
);
  localparam int AW      = $clog2(DEPTH);
  localparam int PW      = AW + 1;
  localparam int DEF_OFS = default_offset(DEPTH);

  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] wr_bin_s, rd_bin_s;
  logic [AW-1:0] ae_ofs;
  logic          wr_fire, rd_fire;
  logic [DW-1:0] rd_q;

  fifo_wr_ctl #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .wr_clk      (wr_clk),
    .rst_n       (rst_n),
    .din         (wr_data),
    .en1_n       (wr_en1_n),
    .en2_ld      (wr_en2_ld),
    .rd_bin_s    (rd_bin_s),
    .wr_fire     (wr_fire),
    .wr_bin      (wr_bin),
    .wr_gray     (wr_gray),
    .ae_ofs      (ae_ofs),
    .full        (full),
    .almost_full (almost_full)
  );

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .en1_n        (rd_en1_n),
    .en2_n        (rd_en2_n),
    .wr_bin_s     (wr_bin_s),
    .ae_ofs       (ae_ofs),
    .rd_fire      (rd_fire),
    .rd_bin       (rd_bin),
    .rd_gray      (rd_gray),
    .empty        (empty),
    .almost_empty (almost_empty)
  );

  // Pointer crossings: index 0 carries write->read, index 1 read->write
  logic [PW-1:0] xing_in  [2];
  logic [PW-1:0] xing_out [2];
  logic          xing_clk [2];

  assign xing_in[0]  = wr_gray;
  assign xing_clk[0] = rd_clk;
  assign xing_in[1]  = rd_gray;
  assign xing_clk[1] = wr_clk;

  for (genvar k = 0; k < 2; k++) begin : g_xing
    fifo_ptr_sync #(.W(PW)) u_sync (
      .clk     (xing_clk[k]),
      .rst_n   (rst_n),
      .gray_in (xing_in[k]),
      .bin_out (xing_out[k])
    );
  end

  assign wr_bin_s = xing_out[0];
  assign rd_bin_s = xing_out[1];

  fifo_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_fire),
    .waddr  (wr_bin[AW-1:0]),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .re     (rd_fire),
    .raddr  (rd_bin[AW-1:0]),
    .q      (rd_q)
  );

  assign rd_data = out_en_n ? {DW{1'bz}} : rd_q;
endmodule

// File: rtl/fifo_pflag_chk.sv
`timescale 1ns/1ps
module fifo_pflag_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7,
  parameter int DW    = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en1_n,
  input logic          wr_en2_ld,
  input logic          rd_en1_n,
  input logic          rd_en2_n,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [PW-1:0] wr_bin,
  input logic [PW-1:0] rd_bin,
  input logic [PW-1:0] wr_bin_s,
  input logic [PW-1:0] rd_bin_s,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray,
  input logic [DW-1:0] rd_q
);
  logic [PW-1:0] w_fill, r_level;
  assign w_fill  = wr_bin - rd_bin_s;
  assign r_level = wr_bin_s - rd_bin;

  a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && !wr_en1_n && wr_en2_ld) |=> (wr_bin == $past(wr_bin)));

  a_r5_fill_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
    w_fill <= PW'(DEPTH));

  a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && !rd_en1_n && !rd_en2_n) |=> ((rd_bin == $past(rd_bin)) && $stable(rd_q)));

  a_r6_level_bound: assert property (@(posedge rd_clk) disable iff (!rst_n)
    r_level <= PW'(DEPTH));

  a_r3_hold_idle: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en1_n || rd_en2_n) |=> $stable(rd_q));

  a_r9_full_in_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full);

  a_r8_empty_in_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty);

  a_r11_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  a_r11_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind dcfifo_pflag fifo_pflag_chk #(.DEPTH(DEPTH), .PW(PW), .DW(DW)) u_chk (
  .wr_clk       (wr_clk),
  .rd_clk       (rd_clk),
  .rst_n        (rst_n),
  .wr_en1_n     (wr_en1_n),
  .wr_en2_ld    (wr_en2_ld),
  .rd_en1_n     (rd_en1_n),
  .rd_en2_n     (rd_en2_n),
  .full         (full),
  .almost_full  (almost_full),
  .empty        (empty),
  .almost_empty (almost_empty),
  .wr_bin       (wr_bin),
  .rd_bin       (rd_bin),
  .wr_bin_s     (wr_bin_s),
  .rd_bin_s     (rd_bin_s),
  .wr_gray      (wr_gray),
  .rd_gray      (rd_gray),
  .rd_q         (rd_q)
);

// File: tb/test_dcfifo_pflag.sv
`timescale 1ns/1ps
module test_dcfifo_pflag;
  localparam int DEPTH = 64;
  localparam int DW    = 9;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst_n  = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
  logic          rd_en1_n = 1'b1, rd_en2_n = 1'b1;
  logic          out_en_n = 1'b0;
  wire  [DW-1:0] rd_data;
  logic          full, almost_full, empty, almost_empty;

  int rd_half = 7;
  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  dcfifo_pflag #(.DEPTH(DEPTH), .DW(DW)) i_dcfifo_pflag (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_data(wr_data), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
    .rd_data(rd_data), .full(full), .almost_full(almost_full),
    .empty(empty), .almost_empty(almost_empty)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] last_rd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset();
    wr_en1_n = 1'b1; wr_en2_ld = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    repeat (2) @(negedge rd_clk);
    rst_n = 1'b1;
    model.delete();
    last_rd = '0;
    @(negedge wr_clk);
  endtask

  task automatic load_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_data = d; wr_en1_n = 1'b0; wr_en2_ld = 1'b0;
    @(negedge wr_clk);
    wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
  endtask

  task automatic program_ofs(input int ae, input int af);
    load_word(DW'(ae));
    load_word(DW'(ae >> 9));
    load_word(DW'(af));
    load_word(DW'(af >> 9));
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_data = DW'($urandom);
      wr_en1_n = 1'b0; wr_en2_ld = 1'b1;
      if (!full) model.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en1_n = 1'b1;
  endtask

  task automatic read_n(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic hit;
      logic [DW-1:0] exp;
      @(negedge rd_clk);
      rd_en1_n = 1'b0; rd_en2_n = 1'b0;
      hit = !empty;
      @(negedge rd_clk);
      rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      if (hit) begin
        exp = model.pop_front();
        chk(tag, 32'(rd_data), 32'(exp));
        last_rd = exp;
      end
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic chk_flags(input string tag, input logic e_ae, input logic e_af,
                           input logic e_full, input logic e_empty);
    chk({tag, " R8 almost_empty"}, 32'(almost_empty), 32'(e_ae));
    chk({tag, " R9 almost_full"},  32'(almost_full),  32'(e_af));
    chk({tag, " R5 full"},         32'(full),         32'(e_full));
    chk({tag, " R6 empty"},        32'(empty),        32'(e_empty));
  endtask

  // Threshold / fill / expected-flag vectors, DEPTH 64
  typedef struct packed {
    logic [7:0] ae;
    logic [7:0] af;
    logic [7:0] fill;
    logic       e_ae;
    logic       e_af;
    logic       e_full;
    logic       e_empty;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd7,  8'd7,  8'd0,  1'b1, 1'b0, 1'b0, 1'b1},
    '{8'd7,  8'd7,  8'd7,  1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd7,  8'd7,  8'd8,  1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd3,  8'd10, 8'd54, 1'b0, 1'b1, 1'b0, 1'b0},
    '{8'd3,  8'd10, 8'd53, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd0,  8'd0,  8'd1,  1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd0,  8'd0,  8'd64, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd20, 8'd5,  8'd20, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd63, 8'd63, 8'd1,  1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic stream_phase(input int n);
    fork
      begin : writer
        int sent = 0;
        while (sent < n) begin
          @(negedge wr_clk);
          if (!full && $urandom_range(0, 3) != 0) begin
            wr_data = DW'($urandom);
            wr_en1_n = 1'b0; wr_en2_ld = 1'b1;
            model.push_back(wr_data);
            sent++;
          end else begin
            wr_en1_n = 1'b1;
            wr_en2_ld = $urandom_range(0, 1) != 0;
          end
        end
        @(negedge wr_clk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
      end
      begin : reader
        int got = 0;
        logic pend = 1'b0;
        while (got < n) begin
          @(negedge rd_clk);
          if (pend) begin
            logic [DW-1:0] exp;
            exp = model.pop_front();
            chk("R1 R3 stream data order", 32'(rd_data), 32'(exp));
            got++;
          end
          pend = (got < n) && !empty && ($urandom_range(0, 2) != 0);
          if (pend) begin
            rd_en1_n = 1'b0; rd_en2_n = 1'b0;
          end else begin
            case ($urandom_range(0, 2))
              0: begin rd_en1_n = 1'b1; rd_en2_n = 1'b0; end
              1: begin rd_en1_n = 1'b0; rd_en2_n = 1'b1; end
              default: begin rd_en1_n = 1'b1; rd_en2_n = 1'b1; end
            endcase
          end
        end
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      end
    join
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    do_reset();

    // R10: reset state and default thresholds
    chk_flags("R10 reset", 1'b1, 1'b0, 1'b0, 1'b1);
    write_n(7);  settle();
    chk("R10 default ae threshold 7 (count 7)", 32'(almost_empty), 32'd1);
    write_n(1);  settle();
    chk("R10 default ae threshold 7 (count 8)", 32'(almost_empty), 32'd0);
    write_n(48); settle();
    chk("R10 default af threshold 7 (free 8)", 32'(almost_full), 32'd0);
    write_n(1);  settle();
    chk("R10 default af threshold 7 (free 7)", 32'(almost_full), 32'd1);
    write_n(7);  settle();
    chk("R5 full at DEPTH", 32'(full), 32'd1);
    // R5: writes while full are dropped
    write_n(3);  settle();
    chk("R5 full holds after dropped writes", 32'(full), 32'd1);
    read_n(64, "R1 R5 drain after full");
    settle();
    chk("R5 no extra word after drain", 32'(empty), 32'd1);

    // R6: read while empty leaves output
    @(negedge rd_clk);
    rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    chk("R6 output held on empty read", 32'(rd_data), 32'(last_rd));
    chk("R6 empty stays", 32'(empty), 32'd1);

    // R4: output enable
    out_en_n = 1'b1; #1;
    chk("R4 output high impedance", 32'(rd_data === {DW{1'bz}}), 32'd1);
    out_en_n = 1'b0; #1;
    chk("R4 output driven", 32'(rd_data), 32'(last_rd));

    // R11: empty falls within synchronizer latency
    write_n(1);
    begin
      int k = 0;
      while (empty && k < 10) begin
        @(posedge rd_clk); #1; k++;
      end
      chk("R11 empty latency <= 4", 32'(k <= 4), 32'd1);
    end
    read_n(1, "R11 single word");

    // R10: reset returns the loader to its first step, mid-fill reset empties
    write_n(10);
    load_word(9'd2);
    do_reset();
    chk_flags("R10 reset mid-fill", 1'b1, 1'b0, 1'b0, 1'b1);
    program_ofs(5, 3);
    settle();
    chk("R2 load writes no RAM word", 32'(empty), 32'd1);
    write_n(5); settle();
    chk("R10 loader restart ae=5 (count 5)", 32'(almost_empty), 32'd1);
    write_n(1); settle();
    chk("R10 loader restart ae=5 (count 6)", 32'(almost_empty), 32'd0);
    read_n(6, "R1 R10 data after reload");

    // Vector table: thresholds, fill, expected flags, drain
    for (int v = 0; v < NV; v++) begin
      do_reset();
      program_ofs(int'(VECS[v].ae), int'(VECS[v].af));
      settle();
      chk("R2 empty after threshold load", 32'(empty), 32'd1);
      write_n(int'(VECS[v].fill));
      settle();
      chk_flags($sformatf("vec%0d", v), VECS[v].e_ae, VECS[v].e_af,
                VECS[v].e_full, VECS[v].e_empty);
      read_n(int'(VECS[v].fill), "R1 R3 table drain");
      settle();
      chk("R6 empty after drain", 32'(empty), 32'd1);
    end

    // Concurrent traffic under several read-clock ratios
    for (int p = 0; p < 3; p++) begin
      do_reset();
      rd_half = $urandom_range(3, 9);
      repeat (4) @(negedge rd_clk);
      stream_phase(150);
      settle();
      chk("R1 empty after stream", 32'(empty), 32'd1);
    end

    summary();
    $finish;
  end
endmodule